// File: doc/BRIEF.md
# Banked Interrupt Controller Register File

This block gathers 72 level-sensitive interrupt lines into one processor interrupt request. The lines are organised as a small direct group of 8 and two wide banks of 32 each. Global source numbers run 0–7 for the direct group, 8–39 for the first bank (bank bit n is source 8+n) and 40–71 for the second bank (bank bit n is source 40+n). A 32-bit register port lets software enable sources, inspect what is pending and hold a word of fast-interrupt routing configuration.

Each source has an enable bit. Software never writes an enable mask as a whole. It writes a word to a set-only register or to a clear-only register of the group, and only the bits written as one are affected. Each bank has a pending word, which is its raw levels ANDed with its enables. The direct-group pending word packs three kinds of information: the enabled direct sources, one summary flag per bank, and shortcut copies of eleven selected bank bits. Software can therefore often identify a source with a single read.

The port is word addressed: `reg_word` is the byte offset divided by four. Reads are combinational on `reg_word`. Writes take effect at the rising clock edge when `wr_en` is high. The asynchronous active-low reset is released through a two-stage synchroniser.

Top module: `irq_bank_ctrl`

## Requirements
- R1: Word index map (byte offset = 4 × index): 0 direct pending, 1 bank1 pending, 2 bank2 pending, 3 fast-routing word, 4 set bank1, 5 set bank2, 6 set direct, 7 clear bank1, 8 clear bank2, 9 clear direct. Indices 10 to 15 read as zero.
- R2: A write to a set index ORs the written bits into that group's enable mask. For the direct group only bits 7:0 count.
- R3: A write to a clear index clears every enable bit of that group whose written bit is one. Enable bits written as zero keep their value.
- R4: Enable bits change only through writes to the set and clear indices. Writes to the pending indices, the fast-routing index or indices 10–15 leave every enable unchanged.
- R5: A read of a set index or a clear index returns that group's current enable mask, zero-extended to 32 bits.
- R6: The bank1 and bank2 pending words (indices 1 and 2) equal the raw source levels ANDed with the enables. The value follows a source level change in the same cycle.
- R7: Bits 7:0 of the direct pending word are the direct sources ANDed with their enables.
- R8: Direct pending bits 10–14 copy bank1 pending bits 7, 9, 10, 18 and 19, in that order. Bits 15–20 copy bank2 pending bits 21, 22, 23, 24, 25 and 30, in that order. Bits 31:21 read zero.
- R9: Direct pending bit 8 (bank1) and bit 9 (bank2) are set only when a pending bit of that bank without a shortcut copy is set.
- R10: `cpu_irq` is high in the cycle after any of direct pending bits 20:0 is set, and low in the cycle after all of them are clear.
- R11: The fast-routing word stores all 32 written bits, reads back unchanged and has no effect on pending words or `cpu_irq`.
- R12: During reset and after its release, every enable bit and the fast-routing word are zero and `cpu_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the word at `reg_word` |
| reg_word | input | 4 | Word index of the register accessed |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `reg_word`, combinational |
| src_basic | input | 8 | Direct-group source levels |
| src_bank1 | input | 32 | Bank1 source levels |
| src_bank2 | input | 32 | Bank2 source levels |
| cpu_irq | output | 1 | Registered aggregate interrupt request |

## Verification
A write to a clear register can land in the same cycle in which the source it masks changes level. The pending read in that cycle and the registered request on the next edge then depend on whether the source change is seen before or after the enable update. The bench provokes this on purpose: in one cycle it raises a bank1 line and clears its enable, and in another it drops a shortcut-mirrored line while a set write enables a different bank bit. A behavioural model, which updates its enable state only at the edge and derives the request from the pre-edge pending state, is compared against `rd_data` and `cpu_irq` on every cycle, so either ordering mistake shows up as a miscompare.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // word indices of the register map (byte offset / 4)
  localparam int IX_PEND_BASIC = 0;
  localparam int IX_PEND_B1    = 1;
  localparam int IX_PEND_B2    = 2;
  localparam int IX_FIQ        = 3;
  localparam int IX_SET_B1     = 4;
  localparam int IX_SET_B2     = 5;
  localparam int IX_SET_BASIC  = 6;
  localparam int IX_CLR_B1     = 7;
  localparam int IX_CLR_B2     = 8;
  localparam int IX_CLR_BASIC  = 9;

  // number of bank bits mirrored into the direct pending word
  localparam int SC1_N = 5;
  localparam int SC2_N = 6;

  function automatic int sc1_bit(input int i);
    case (i)
      0:       return 7;
      1:       return 9;
      2:       return 10;
      3:       return 18;
      default: return 19;
    endcase
  endfunction

  function automatic int sc2_bit(input int i);
    if (i < 5) return 21 + i;
    return 30;
  endfunction

  function automatic bit is_sc1(input int b);
    for (int i = 0; i < SC1_N; i++)
      if (sc1_bit(i) == b) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit is_sc2(input int b);
    for (int i = 0; i < SC2_N; i++)
      if (sc2_bit(i) == b) return 1'b1;
    return 1'b0;
  endfunction

  typedef struct packed {
    logic set_basic;
    logic set_b1;
    logic set_b2;
    logic clr_basic;
    logic clr_b1;
    logic clr_b2;
    logic fiq_wr;
  } wr_stb_t;

endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/irqc_en_group.sv
module irqc_en_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] en
);

  logic [W-1:0] en_d;
  logic         en_ce;

  always_comb begin
    en_ce = set_stb | clr_stb;
    en_d  = en;
    if (set_stb)      en_d = en | wbits;
    else if (clr_stb) en_d = en & ~wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en <= '0;
    else if (en_ce) en <= en_d;
  end

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((en & $past(wbits)) == $past(wbits)));

  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((en & $past(wbits)) == '0));

  // R3
  en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb || clr_stb) |=> ((en & ~$past(wbits)) == ($past(en) & ~$past(wbits))));

  // R4
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_stb || clr_stb) |=> $stable(en));

endmodule

// File: rtl/irqc_pend_map.sv
module irqc_pend_map import irqc_pkg::*; #(
  parameter int BASIC_N = 8,
  parameter int BANK_N  = 32,
  parameter int DATA_W  = 32
) (
  input  logic [BASIC_N-1:0] src_basic,
  input  logic [BANK_N-1:0]  src_b1,
  input  logic [BANK_N-1:0]  src_b2,
  input  logic [BASIC_N-1:0] en_basic,
  input  logic [BANK_N-1:0]  en_b1,
  input  logic [BANK_N-1:0]  en_b2,
  output logic [DATA_W-1:0]  pend_basic,
  output logic [BANK_N-1:0]  pend_b1,
  output logic [BANK_N-1:0]  pend_b2,
  output logic               pend_any
);

  localparam int SUM1_POS = BASIC_N;
  localparam int SUM2_POS = BASIC_N + 1;
  localparam int SC1_BASE = BASIC_N + 2;
  localparam int SC2_BASE = SC1_BASE + SC1_N;
  localparam int USED_W   = SC2_BASE + SC2_N;

  logic [BANK_N-1:0] b1_direct;
  logic [BANK_N-1:0] b2_direct;

  assign pend_b1 = src_b1 & en_b1;
  assign pend_b2 = src_b2 & en_b2;

  // bank bits that have no shortcut copy feed the summary flags
  for (genvar j = 0; j < BANK_N; j++) begin : g_direct
    if (is_sc1(j)) begin : g_b1_sc
      assign b1_direct[j] = 1'b0;
    end else begin : g_b1_plain
      assign b1_direct[j] = pend_b1[j];
    end
    if (is_sc2(j)) begin : g_b2_sc
      assign b2_direct[j] = 1'b0;
    end else begin : g_b2_plain
      assign b2_direct[j] = pend_b2[j];
    end
  end

  assign pend_basic[BASIC_N-1:0] = src_basic & en_basic;
  assign pend_basic[SUM1_POS]    = |b1_direct;
  assign pend_basic[SUM2_POS]    = |b2_direct;

  for (genvar i = 0; i < SC1_N; i++) begin : g_sc1
    assign pend_basic[SC1_BASE+i] = pend_b1[sc1_bit(i)];
  end

  for (genvar i = 0; i < SC2_N; i++) begin : g_sc2
    assign pend_basic[SC2_BASE+i] = pend_b2[sc2_bit(i)];
  end

  if (DATA_W > USED_W) begin : g_pad
    assign pend_basic[DATA_W-1:USED_W] = '0;
  end

  assign pend_any = |pend_basic[USED_W-1:0];

endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl import irqc_pkg::*; #(
  parameter int BASIC_N = 8,
  parameter int BANK_N  = 32,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   reg_word,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [BASIC_N-1:0] src_basic,
  input  logic [BANK_N-1:0]  src_bank1,
  input  logic [BANK_N-1:0]  src_bank2,
  output logic               cpu_irq
);

  logic              rst_i_n;
  wr_stb_t           stb;
  logic [BASIC_N-1:0] en_basic;
  logic [BANK_N-1:0]  en_b1;
  logic [BANK_N-1:0]  en_b2;
  logic [DATA_W-1:0]  pend_basic;
  logic [BANK_N-1:0]  pend_b1;
  logic [BANK_N-1:0]  pend_b2;
  logic               pend_any;
  logic [DATA_W-1:0]  fiq_q;
  logic [DATA_W-1:0]  fiq_d;
  logic               irq_d;

  irqc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // write decode
  always_comb begin
    stb           = '0;
    stb.set_b1    = wr_en && (reg_word == IDX_W'(IX_SET_B1));
    stb.set_b2    = wr_en && (reg_word == IDX_W'(IX_SET_B2));
    stb.set_basic = wr_en && (reg_word == IDX_W'(IX_SET_BASIC));
    stb.clr_b1    = wr_en && (reg_word == IDX_W'(IX_CLR_B1));
    stb.clr_b2    = wr_en && (reg_word == IDX_W'(IX_CLR_B2));
    stb.clr_basic = wr_en && (reg_word == IDX_W'(IX_CLR_BASIC));
    stb.fiq_wr    = wr_en && (reg_word == IDX_W'(IX_FIQ));
  end

  irqc_en_group #(.W(BASIC_N)) u_en_basic (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .set_stb (stb.set_basic),
    .clr_stb (stb.clr_basic),
    .wbits   (wr_data[BASIC_N-1:0]),
    .en      (en_basic)
  );

  irqc_en_group #(.W(BANK_N)) u_en_b1 (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .set_stb (stb.set_b1),
    .clr_stb (stb.clr_b1),
    .wbits   (wr_data[BANK_N-1:0]),
    .en      (en_b1)
  );

  irqc_en_group #(.W(BANK_N)) u_en_b2 (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .set_stb (stb.set_b2),
    .clr_stb (stb.clr_b2),
    .wbits   (wr_data[BANK_N-1:0]),
    .en      (en_b2)
  );

  irqc_pend_map #(
    .BASIC_N (BASIC_N),
    .BANK_N  (BANK_N),
    .DATA_W  (DATA_W)
  ) u_pend (
    .src_basic  (src_basic),
    .src_b1     (src_bank1),
    .src_b2     (src_bank2),
    .en_basic   (en_basic),
    .en_b1      (en_b1),
    .en_b2      (en_b2),
    .pend_basic (pend_basic),
    .pend_b1    (pend_b1),
    .pend_b2    (pend_b2),
    .pend_any   (pend_any)
  );

  // fast-routing word: storage only
  always_comb begin
    fiq_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)        fiq_q <= '0;
    else if (stb.fiq_wr) fiq_q <= fiq_d;
  end

  // aggregate request, one register stage
  always_comb begin
    irq_d = pend_any;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) cpu_irq <= 1'b0;
    else          cpu_irq <= irq_d;
  end

  // read mux
  always_comb begin
    rd_data = '0;
    case (reg_word)
      IDX_W'(IX_PEND_BASIC): rd_data = pend_basic;
      IDX_W'(IX_PEND_B1):    rd_data[BANK_N-1:0] = pend_b1;
      IDX_W'(IX_PEND_B2):    rd_data[BANK_N-1:0] = pend_b2;
      IDX_W'(IX_FIQ):        rd_data = fiq_q;
      IDX_W'(IX_SET_B1),
      IDX_W'(IX_CLR_B1):     rd_data[BANK_N-1:0] = en_b1;
      IDX_W'(IX_SET_B2),
      IDX_W'(IX_CLR_B2):     rd_data[BANK_N-1:0] = en_b2;
      IDX_W'(IX_SET_BASIC),
      IDX_W'(IX_CLR_BASIC):  rd_data[BASIC_N-1:0] = en_basic;
      default:               rd_data = '0;
    endcase
  end

  // R10
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    1'b1 |=> (cpu_irq == $past(pend_any)));

  // R9
  sum1_src_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    pend_basic[BASIC_N] |-> ((src_bank1 & en_b1) != '0));

  // R11
  fiq_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !stb.fiq_wr |=> $stable(fiq_q));

endmodule

// File: tb/irq_bank_ctrl_bench.sv
`timescale 1ns/1ps
module irq_bank_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  reg_word = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  src_basic = '0;
  logic [31:0] src_bank1 = '0;
  logic [31:0] src_bank2 = '0;
  logic        cpu_irq;

  always #4 clk = ~clk;

  irq_bank_ctrl u_irq_bank_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .reg_word  (reg_word),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .src_basic (src_basic),
    .src_bank1 (src_bank1),
    .src_bank2 (src_bank2),
    .cpu_irq   (cpu_irq)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  bit    chk_on = 1'b0;
  bit    done = 1'b0;
  string phase = "R12 reset";

  // reference model state
  bit [7:0]  m_en0;
  bit [31:0] m_en1;
  bit [31:0] m_en2;
  bit [31:0] m_fiq;
  bit        m_irq;
  bit [1:0]  m_rs;

  function automatic bit [31:0] m_pend_basic();
    bit [31:0] r;
    bit [31:0] p1;
    bit [31:0] p2;
    int s1[5] = '{7, 9, 10, 18, 19};
    int s2[6] = '{21, 22, 23, 24, 25, 30};
    r = '0;
    p1 = src_bank1 & m_en1;
    p2 = src_bank2 & m_en2;
    r[7:0] = src_basic & m_en0;
    foreach (s1[i]) begin r[10+i] = p1[s1[i]]; p1[s1[i]] = 1'b0; end
    foreach (s2[i]) begin r[15+i] = p2[s2[i]]; p2[s2[i]] = 1'b0; end
    r[8] = (p1 != 0);
    r[9] = (p2 != 0);
    return r;
  endfunction

  function automatic bit [31:0] m_read(input int ix);
    case (ix)
      0:       return m_pend_basic();
      1:       return src_bank1 & m_en1;
      2:       return src_bank2 & m_en2;
      3:       return m_fiq;
      4, 7:    return m_en1;
      5, 8:    return m_en2;
      6, 9:    return {24'd0, m_en0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string ix_tag(input int ix);
    case (ix)
      0:       return "R7 R8 R9";
      1, 2:    return "R6";
      3:       return "R11";
      4, 5, 6: return "R5 R2";
      7, 8, 9: return "R5 R3";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en0 = '0; m_en1 = '0; m_en2 = '0; m_fiq = '0; m_irq = 1'b0; m_rs = '0;
    end else begin
      if (m_rs[1]) begin
        m_irq = (m_pend_basic() != 0);
        if (wr_en) begin
          case (int'(reg_word))
            3: m_fiq = wr_data;
            4: m_en1 = m_en1 | wr_data;
            5: m_en2 = m_en2 | wr_data;
            6: m_en0 = m_en0 | wr_data[7:0];
            7: m_en1 = m_en1 & ~wr_data;
            8: m_en2 = m_en2 & ~wr_data;
            9: m_en0 = m_en0 & ~wr_data[7:0];
            default: ;
          endcase
        end
      end
      m_rs = {m_rs[0], 1'b1};
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (chk_on && !done) begin
      bit [31:0] exp_rd;
      exp_rd = m_read(int'(reg_word));
      n_vec += 2;
      if (rd_data !== exp_rd) begin
        n_bad++;
        $display("FAIL %s [%s] word %0d rd_data actual=%h expected=%h",
                 ix_tag(int'(reg_word)), phase, reg_word, rd_data, exp_rd);
      end
      if (cpu_irq !== m_irq) begin
        n_bad++;
        $display("FAIL R10 [%s] cpu_irq actual=%b expected=%b", phase, cpu_irq, m_irq);
      end
    end
  end

  task automatic step(input bit w, input int ix, input bit [31:0] d);
    @(posedge clk);
    #2;
    wr_en = w;
    reg_word = 4'(ix);
    wr_data = d;
  endtask

  task automatic sweep();
    for (int i = 0; i < 16; i++) step(1'b0, i, 32'd0);
  endtask

  task automatic do_reset();
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (3) step(1'b0, 0, 0);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(posedge clk);
    chk_on = 1'b1;
    phase = "R12 reset";
    do_reset();
    src_basic = 8'hFF; src_bank1 = '1; src_bank2 = '1;
    sweep();

    phase = "R2 set";
    step(1'b1, 6, 32'hFFFF_FF5A);
    step(1'b1, 4, 32'h0000_0008);
    step(1'b1, 5, 32'h8000_0001);
    step(1'b1, 4, 32'h0000_0100);
    sweep();

    phase = "R3 clear";
    step(1'b1, 9, 32'h0000_0042);
    step(1'b1, 7, 32'h0000_0000);
    step(1'b1, 8, 32'h8000_0000);
    sweep();

    phase = "R4 stray writes";
    for (int i = 0; i < 16; i++)
      if (i < 3 || i > 9) step(1'b1, i, 32'hFFFF_FFFF);
    sweep();

    phase = "R9 shortcut only";
    step(1'b1, 9, 32'hFF);
    step(1'b1, 7, 32'hFFFF_FFFF);
    step(1'b1, 8, 32'hFFFF_FFFF);
    src_basic = '0; src_bank1 = 32'h000C_0680; src_bank2 = 32'h43E0_0000;
    step(1'b1, 4, 32'h000C_0680);
    step(1'b1, 5, 32'h43E0_0000);
    step(1'b0, 0, 0); step(1'b0, 0, 0);
    phase = "R8 mirror walk";
    for (int i = 0; i < 32; i++) begin
      src_bank1 = 32'(1) << i; src_bank2 = 32'(1) << i;
      step(1'b1, 4, 32'hFFFF_FFFF);
      step(1'b1, 5, 32'hFFFF_FFFF);
      step(1'b0, 0, 0);
      step(1'b0, 1, 0);
      step(1'b0, 2, 0);
    end

    phase = "R10 same-cycle clear";
    src_bank1 = '0; src_bank2 = '0;
    step(1'b0, 0, 0); step(1'b0, 0, 0);
    step(1'b1, 7, 32'h0000_0008);
    src_bank1 = 32'h0000_0008;
    step(1'b0, 0, 0); step(1'b0, 0, 0);
    src_bank1 = 32'h0000_0080;
    step(1'b1, 4, 32'h0000_0008);
    src_bank1 = 32'h0000_0008;
    step(1'b0, 0, 0); step(1'b0, 0, 0);

    phase = "R11 routing word";
    step(1'b1, 7, 32'hFFFF_FFFF);
    step(1'b1, 8, 32'hFFFF_FFFF);
    src_bank2 = '1; src_basic = '1;
    step(1'b1, 3, 32'hA5C3_0FF0);
    step(1'b0, 3, 0); step(1'b0, 0, 0); step(1'b0, 0, 0);

    phase = "R1 R6 random";
    for (int n = 0; n < 4000; n++) begin
      src_basic = 8'($urandom & $urandom);
      src_bank1 = $urandom & $urandom & $urandom;
      src_bank2 = $urandom & $urandom & $urandom;
      step(($urandom % 3) == 0, int'($urandom % 16), $urandom & $urandom);
    end

    phase = "R12 mid-run reset";
    do_reset();
    sweep();

    step(1'b0, 0, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule